// File: doc/BRIEF.md
# Serial Flash Raster Viewer

The block streams the contents of an external serial flash memory onto a VGA monitor, one bit per pixel clock, so the memory can be inspected by eye. Each visible line starts its own flash read: chip select drops during horizontal blanking, a read command and a 24-bit address are shifted out, and the returned bit stream fills the visible part of the line. The serial clock is the inverted system clock and never stops. Only chip select frames a transfer.

Lines come in groups of four that alternate between two display paths. The buffered path shows the data bit after it has been clocked into a flop. The direct path routes the flash data pin straight to the colour outputs. Both paths are timed so that the same address lands on the same pixel column, which lets the two renderings be compared side by side.

A strap input picks one of two display timings. In the wide timing each clock stands for four screen pixels. A second input chooses whether the sync and colour outputs leave through a register stage or straight from logic.

Top module: `flash_vga_viewer`

## Requirements
- R1: The horizontal counter runs 0..HTOT-1 and the vertical counter steps once per line over 0..VTOT-1. Each timing set is visible, front porch, sync, back porch. Its sync pulse covers counts VIS+FP up to, but not including, VIS+FP+SYNC. `timing_sel` low picks set A and high picks set B.
- R2: With set A, both syncs are active low. With set B, hsync is active low and vsync is active high.
- R3: `spi_sclk` is always the inverse of `clk`. `spi_hold_n`, `spi_wp_n` and `spi_rst_n` are held high at all times.
- R4: Chip select is low only in two cases. The first is the lead window of a line whose next line is visible. The next line of line v is v+1, or 0 after VTOT-1. The lead window is the last 33 clocks of the line when the next line is buffered, and the last 32 when it is direct. The second case is the visible part of a line whose read was issued. Chip select is high in reset.
- R5: Each transfer sends 0x03 followed by a 24-bit address, MSB first. MOSI changes on the rising edge of `clk`.
- R6: Chip select is high from horizontal count HVIS until the next lead window.
- R7: Visible line v is read from address v×BPL, where BPL = HVIS/8. The address counter clears on the first vsync line, so the addresses hold from the second frame after reset.
- R8: Lines with bit 2 of the line number clear use the buffered path, and lines with it set use the direct path. On both paths, pixel h shows bit 7-(h mod 8) of byte base+h/8 (MSB first), on the same clock.
- R9: During the visible area all six colour outputs equal the pixel bit. In blanking they are 0.
- R10: With `out_reg_en` high, hsync, vsync and the colours equal their unregistered values of the previous clock. With it low, they follow in the same clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System and pixel clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| timing_sel | input | 1 | Display timing strap: 0 = set A, 1 = set B |
| out_reg_en | input | 1 | 1 = registered VGA outputs |
| spi_miso | input | 1 | Serial data from flash |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_sclk | output | 1 | Serial clock, inverted `clk` |
| spi_hold_n | output | 1 | Hold pin, held inactive |
| spi_wp_n | output | 1 | Write-protect pin, held inactive |
| spi_rst_n | output | 1 | Flash reset pin, held inactive |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| red | output | 2 | Red level |
| green | output | 2 | Green level |
| blue | output | 2 | Blue level |

## Verification
The hardest case to reach is alignment across the two paths. A direct line shows a bit that a flash model launches just after the falling serial clock edge. A buffered line shows that same kind of bit one flop later, from a read started one clock earlier. Both must land on the same column. The bench therefore models a flash that answers with a small delay after each rising system clock. It predicts every pixel from the line address rule, so a skew on either path shows up. Reset-to-frame sequencing matters too: the address rule holds only after the first vsync. The runs therefore span several frames under both timings and both output modes. A reduced timing keeps each frame short.

// File: rtl/viewer_pkg.sv
package viewer_pkg;
    localparam int CW       = 11;
    localparam int AW       = 24;
    localparam int CMD_W    = 8;
    localparam int PRE_BITS = CMD_W + AW;
    localparam logic [CMD_W-1:0] RD_CMD = 8'h03;

    typedef struct packed {
        logic [CW-1:0] h;
        logic [CW-1:0] v;
    } scan_t;

    typedef struct packed {
        logic                cs_n;
        logic [PRE_BITS-1:0] sh;
        logic [AW-1:0]       nxt_addr;
        logic                miso_q;
    } fseq_t;

    typedef struct packed {
        logic       hs;
        logic       vs;
        logic [1:0] r;
        logic [1:0] g;
        logic [1:0] b;
    } vout_t;
endpackage

// File: rtl/vga_timing.sv
module vga_timing
    import viewer_pkg::*;
#(
    parameter int H_VIS_A = 640, parameter int H_FP_A = 16, parameter int H_SY_A = 96, parameter int H_BP_A = 48,
    parameter int V_VIS_A = 480, parameter int V_FP_A = 10, parameter int V_SY_A = 2,  parameter int V_BP_A = 33,
    parameter int H_VIS_B = 360, parameter int H_FP_B = 20, parameter int H_SY_B = 38, parameter int H_BP_B = 58,
    parameter int V_VIS_B = 900, parameter int V_FP_B = 1,  parameter int V_SY_B = 3,  parameter int V_BP_B = 28
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          sel,
    output scan_t         pos,
    output logic [CW-1:0] hvis,
    output logic [CW-1:0] htot,
    output logic [CW-1:0] vvis,
    output logic [CW-1:0] vtot,
    output logic          hs_act,
    output logic          vs_act,
    output logic          frame_start
);
    localparam int HSB_A = H_VIS_A + H_FP_A;
    localparam int HSE_A = HSB_A + H_SY_A;
    localparam int HT_A  = HSE_A + H_BP_A;
    localparam int VSB_A = V_VIS_A + V_FP_A;
    localparam int VSE_A = VSB_A + V_SY_A;
    localparam int VT_A  = VSE_A + V_BP_A;
    localparam int HSB_B = H_VIS_B + H_FP_B;
    localparam int HSE_B = HSB_B + H_SY_B;
    localparam int HT_B  = HSE_B + H_BP_B;
    localparam int VSB_B = V_VIS_B + V_FP_B;
    localparam int VSE_B = VSB_B + V_SY_B;
    localparam int VT_B  = VSE_B + V_BP_B;

    logic [CW-1:0] hsb, hse, vsb, vse;
    scan_t cur_q, nxt_d;

    always_comb begin
        if (sel) begin
            hvis = CW'(H_VIS_B); htot = CW'(HT_B); hsb = CW'(HSB_B); hse = CW'(HSE_B);
            vvis = CW'(V_VIS_B); vtot = CW'(VT_B); vsb = CW'(VSB_B); vse = CW'(VSE_B);
        end else begin
            hvis = CW'(H_VIS_A); htot = CW'(HT_A); hsb = CW'(HSB_A); hse = CW'(HSE_A);
            vvis = CW'(V_VIS_A); vtot = CW'(VT_A); vsb = CW'(VSB_A); vse = CW'(VSE_A);
        end
    end

    always_comb begin
        nxt_d = cur_q;
        if (cur_q.h >= htot - 1'b1) begin
            nxt_d.h = '0;
            nxt_d.v = (cur_q.v >= vtot - 1'b1) ? '0 : cur_q.v + 1'b1;
        end else begin
            nxt_d.h = cur_q.h + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign pos         = cur_q;
    assign hs_act      = (cur_q.h >= hsb) && (cur_q.h < hse);
    assign vs_act      = (cur_q.v >= vsb) && (cur_q.v < vse);
    assign frame_start = (cur_q.h == '0) && (cur_q.v == vsb);

    AST_H_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.h == htot - 1'b1) |=> (cur_q.h == '0)); // R1
    AST_V_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.h < htot - 1'b1) |=> $stable(cur_q.v)); // R1
endmodule

// File: rtl/flash_seq.sv
module flash_seq
    import viewer_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  scan_t         pos,
    input  logic [CW-1:0] hvis,
    input  logic [CW-1:0] htot,
    input  logic [CW-1:0] vvis,
    input  logic [CW-1:0] vtot,
    input  logic [AW-1:0] bpl,
    input  logic          frame_start,
    input  logic          miso,
    output logic          cs_n,
    output logic          mosi,
    output logic          miso_q
);
    localparam int LEAD_DIR = PRE_BITS;
    localparam int LEAD_BUF = PRE_BITS + 1;

    fseq_t q, d;
    logic [CW-1:0] nv;
    logic          nv_vis, nv_dir, start;

    always_comb begin
        nv     = (pos.v >= vtot - 1'b1) ? '0 : pos.v + 1'b1;
        nv_vis = nv < vvis;
        nv_dir = nv[2];
        start  = nv_vis && (nv_dir ? (pos.h == htot - CW'(LEAD_DIR + 1))
                                   : (pos.h == htot - CW'(LEAD_BUF + 1)));
        d        = q;
        d.miso_q = miso;
        if (!q.cs_n) d.sh = q.sh << 1;
        if (!q.cs_n && (pos.h == hvis - 1'b1)) d.cs_n = 1'b1;
        if (start) begin
            d.cs_n     = 1'b0;
            d.sh       = {RD_CMD, q.nxt_addr};
            d.nxt_addr = q.nxt_addr + bpl;
        end
        if (frame_start) d.nxt_addr = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign cs_n   = q.cs_n;
    assign mosi   = q.sh[PRE_BITS-1];
    assign miso_q = q.miso_q;

    logic [CW:0] lo_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      lo_q <= '0;
        else if (q.cs_n) lo_q <= '0;
        else             lo_q <= lo_q + 1'b1;
    end

    AST_CS_END: assert property (@(posedge clk) disable iff (!rst_n)
        (pos.h == hvis) |-> q.cs_n); // R6
    AST_CMD_LEAD: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(q.cs_n) |-> !mosi); // R5
    AST_CS_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        !q.cs_n |-> (lo_q < {1'b0, hvis} + (CW+1)'(LEAD_BUF))); // R4
endmodule

// File: rtl/pix_out.sv
module pix_out
    import viewer_pkg::*;
#(
    parameter bit HPOL_A = 1'b0, parameter bit VPOL_A = 1'b0,
    parameter bit HPOL_B = 1'b0, parameter bit VPOL_B = 1'b1
) (
    input  logic          clk,
    input  logic          sel,
    input  logic          reg_en,
    input  scan_t         pos,
    input  logic [CW-1:0] hvis,
    input  logic [CW-1:0] vvis,
    input  logic          hs_act,
    input  logic          vs_act,
    input  logic          miso,
    input  logic          miso_q,
    output vout_t         vo
);
    vout_t c_d, c_q;
    logic  hpol, vpol, vis, pix;

    always_comb begin
        hpol = sel ? HPOL_B : HPOL_A;
        vpol = sel ? VPOL_B : VPOL_A;
        vis  = (pos.h < hvis) && (pos.v < vvis);
        pix  = vis && (pos.v[2] ? miso : miso_q);
        c_d.hs = hpol ? hs_act : ~hs_act;
        c_d.vs = vpol ? vs_act : ~vs_act;
        c_d.r  = {2{pix}};
        c_d.g  = {2{pix}};
        c_d.b  = {2{pix}};
    end

    always_ff @(posedge clk) c_q <= c_d;

    assign vo = reg_en ? c_q : c_d;
endmodule

// File: rtl/flash_vga_viewer.sv
module flash_vga_viewer
    import viewer_pkg::*;
#(
    parameter int H_VIS_A = 640, parameter int H_FP_A = 16, parameter int H_SY_A = 96, parameter int H_BP_A = 48,
    parameter int V_VIS_A = 480, parameter int V_FP_A = 10, parameter int V_SY_A = 2,  parameter int V_BP_A = 33,
    parameter int H_VIS_B = 360, parameter int H_FP_B = 20, parameter int H_SY_B = 38, parameter int H_BP_B = 58,
    parameter int V_VIS_B = 900, parameter int V_FP_B = 1,  parameter int V_SY_B = 3,  parameter int V_BP_B = 28,
    parameter bit HPOL_A = 1'b0, parameter bit VPOL_A = 1'b0,
    parameter bit HPOL_B = 1'b0, parameter bit VPOL_B = 1'b1
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       timing_sel,
    input  logic       out_reg_en,
    input  logic       spi_miso,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    output logic       spi_sclk,
    output logic       spi_hold_n,
    output logic       spi_wp_n,
    output logic       spi_rst_n,
    output logic       hsync,
    output logic       vsync,
    output logic [1:0] red,
    output logic [1:0] green,
    output logic [1:0] blue
);
    localparam int BPL_A = H_VIS_A / 8;
    localparam int BPL_B = H_VIS_B / 8;

    scan_t         pos;
    logic [CW-1:0] hvis, htot, vvis, vtot;
    logic          hs_act, vs_act, frame_start, miso_q;
    logic [AW-1:0] bpl;
    vout_t         vo;

    assign bpl = timing_sel ? AW'(BPL_B) : AW'(BPL_A);

    vga_timing #(
        .H_VIS_A(H_VIS_A), .H_FP_A(H_FP_A), .H_SY_A(H_SY_A), .H_BP_A(H_BP_A),
        .V_VIS_A(V_VIS_A), .V_FP_A(V_FP_A), .V_SY_A(V_SY_A), .V_BP_A(V_BP_A),
        .H_VIS_B(H_VIS_B), .H_FP_B(H_FP_B), .H_SY_B(H_SY_B), .H_BP_B(H_BP_B),
        .V_VIS_B(V_VIS_B), .V_FP_B(V_FP_B), .V_SY_B(V_SY_B), .V_BP_B(V_BP_B)
    ) u_tim (
        .clk(clk), .rst_n(rst_n), .sel(timing_sel), .pos(pos),
        .hvis(hvis), .htot(htot), .vvis(vvis), .vtot(vtot),
        .hs_act(hs_act), .vs_act(vs_act), .frame_start(frame_start)
    );

    flash_seq u_seq (
        .clk(clk), .rst_n(rst_n), .pos(pos), .hvis(hvis), .htot(htot),
        .vvis(vvis), .vtot(vtot), .bpl(bpl), .frame_start(frame_start),
        .miso(spi_miso), .cs_n(spi_cs_n), .mosi(spi_mosi), .miso_q(miso_q)
    );

    pix_out #(
        .HPOL_A(HPOL_A), .VPOL_A(VPOL_A), .HPOL_B(HPOL_B), .VPOL_B(VPOL_B)
    ) u_pix (
        .clk(clk), .sel(timing_sel), .reg_en(out_reg_en), .pos(pos),
        .hvis(hvis), .vvis(vvis), .hs_act(hs_act), .vs_act(vs_act),
        .miso(spi_miso), .miso_q(miso_q), .vo(vo)
    );

    assign spi_sclk   = ~clk;
    assign spi_hold_n = 1'b1;
    assign spi_wp_n   = 1'b1;
    assign spi_rst_n  = 1'b1;
    assign hsync      = vo.hs;
    assign vsync      = vo.vs;
    assign red        = vo.r;
    assign green      = vo.g;
    assign blue       = vo.b;
endmodule

// File: tb/sim_flash_vga_viewer.sv
module sim_flash_vga_viewer;
    localparam int AHV = 16, AHF = 4, AHS = 6, AHB = 26;
    localparam int AVV = 10, AVF = 2, AVS = 2, AVB = 2;
    localparam int BHV = 24, BHF = 2, BHS = 4, BHB = 32;
    localparam int BVV = 12, BVF = 1, BVS = 3, BVB = 2;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic rst_n = 1'b0, timing_sel = 1'b0, out_reg_en = 1'b0, spi_miso = 1'b0;
    logic spi_cs_n, spi_mosi, spi_sclk, spi_hold_n, spi_wp_n, spi_rst_n, hsync, vsync;
    logic [1:0] red, green, blue;

    flash_vga_viewer #(
        .H_VIS_A(AHV), .H_FP_A(AHF), .H_SY_A(AHS), .H_BP_A(AHB),
        .V_VIS_A(AVV), .V_FP_A(AVF), .V_SY_A(AVS), .V_BP_A(AVB),
        .H_VIS_B(BHV), .H_FP_B(BHF), .H_SY_B(BHS), .H_BP_B(BHB),
        .V_VIS_B(BVV), .V_FP_B(BVF), .V_SY_B(BVS), .V_BP_B(BVB)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .timing_sel(timing_sel), .out_reg_en(out_reg_en),
        .spi_miso(spi_miso), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_sclk(spi_sclk),
        .spi_hold_n(spi_hold_n), .spi_wp_n(spi_wp_n), .spi_rst_n(spi_rst_n),
        .hsync(hsync), .vsync(vsync), .red(red), .green(green), .blue(blue)
    );

    int checks = 0, errors = 0, cyc = 0;
    bit done = 1'b0;
    int HV, HF, HS, HB, VV, VF, VS, VB, HT, VT, BPL;
    bit HP, VP;
    logic [7:0] key = 8'h00;
    int bh = 0, bv = 0, frame = 0;
    bit prev_valid = 1'b0, was_low = 1'b0;
    logic p_hs, p_vs, p_pix;
    bit p_known;

    task automatic set_timing(input bit m);
        if (m) begin
            HV = BHV; HF = BHF; HS = BHS; HB = BHB; VV = BVV; VF = BVF; VS = BVS; VB = BVB;
            HP = 1'b0; VP = 1'b1;
        end else begin
            HV = AHV; HF = AHF; HS = AHS; HB = AHB; VV = AVV; VF = AVF; VS = AVS; VB = AVB;
            HP = 1'b0; VP = 1'b0;
        end
        HT = HV + HF + HS + HB; VT = VV + VF + VS + VB; BPL = HV / 8;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at h=%0d v=%0d: act=%0d exp=%0d", req, bh, bv, act, exp);
        end
    endtask

    task automatic finish_up();
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic logic [7:0] memb(input logic [23:0] a);
        logic [7:0] m;
        m = a[7:0] * 8'd29;
        return m ^ a[15:8] ^ key;
    endfunction

    function automatic logic sbit(input logic [23:0] base, input int idx);
        logic [7:0] b;
        b = memb(base + 24'(idx / 8));
        return b[7 - (idx % 8)];
    endfunction

    // flash model: sample on rising serial clock, answer shortly after falling serial clock
    int in_cnt = 0, out_idx = 0;
    logic [31:0] hdr = '0;
    always @(negedge clk) begin
        if (spi_cs_n) begin
            in_cnt = 0; out_idx = 0;
        end else if (in_cnt < 32) begin
            hdr = {hdr[30:0], spi_mosi};
            in_cnt++;
        end
    end
    always @(posedge clk) begin
        #1;
        if (!spi_cs_n && in_cnt == 32) begin
            spi_miso = sbit(hdr[23:0], out_idx);
            out_idx++;
        end else begin
            spi_miso = 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (!rst_n) begin
            bh = 0; bv = 0; frame = 0;
        end else if (bh == HT - 1) begin
            bh = 0;
            if (bv == VT - 1) begin bv = 0; frame++; end
            else bv++;
        end else begin
            bh++;
        end
        if (cyc > 180000 && !done) begin
            errors++;
            $display("FAIL R1 watchdog: act=%0d exp=%0d", cyc, 180000);
            finish_up();
        end
    end

    always @(posedge clk) begin
        #2;
        if (rst_n && !done) chk(spi_sclk == 1'b0, "R3 sclk high phase", int'(spi_sclk), 0);
    end

    always @(negedge clk) begin
        if (!rst_n || done) begin
            prev_valid = 1'b0; was_low = 1'b0;
        end else begin
            bit hs_a, vs_a, vis, known, e_hs, e_vs, e_pix, e_cs_low;
            int nv, lead;
            hs_a = (bh >= HV + HF) && (bh < HV + HF + HS);
            vs_a = (bv >= VV + VF) && (bv < VV + VF + VS);
            e_hs = HP ? hs_a : !hs_a;
            e_vs = VP ? vs_a : !vs_a;
            vis  = (bh < HV) && (bv < VV);
            known = !vis || (frame >= 1);
            e_pix = vis ? sbit(24'(bv * BPL), bh) : 1'b0;
            nv   = (bv == VT - 1) ? 0 : bv + 1;
            lead = ((nv & 4) != 0) ? 32 : 33;
            e_cs_low = (vis && !(frame == 0 && bv == 0)) || (nv < VV && bh >= HT - lead);

            chk(spi_cs_n == !e_cs_low, (bh >= HV && bh < HT - 33) ? "R6 cs idle" : "R4 cs window",
                int'(spi_cs_n), int'(!e_cs_low));
            chk(spi_sclk && spi_hold_n && spi_wp_n && spi_rst_n, "R3 pins",
                int'({spi_sclk, spi_hold_n, spi_wp_n, spi_rst_n}), 15);

            if (!out_reg_en || prev_valid) begin
                logic xh, xv, xp;
                bit xk;
                xh = out_reg_en ? p_hs  : e_hs;
                xv = out_reg_en ? p_vs  : e_vs;
                xp = out_reg_en ? p_pix : e_pix;
                xk = out_reg_en ? p_known : known;
                chk(hsync == xh, out_reg_en ? "R10 hsync delay" : "R1 R2 hsync", int'(hsync), int'(xh));
                chk(vsync == xv, out_reg_en ? "R10 vsync delay" : "R1 R2 vsync", int'(vsync), int'(xv));
                if (xk)
                    chk({red, green, blue} == {6{xp}},
                        ((bv & 4) != 0) ? "R8 R9 direct pixel" : "R8 R9 buffered pixel",
                        int'({red, green, blue}), int'({6{xp}}));
            end

            if (spi_cs_n && was_low && frame >= 1) begin
                chk(hdr[31:24] == 8'h03, "R5 command", int'(hdr[31:24]), 3);
                chk(hdr[23:0] == 24'(bv * BPL), "R7 line address", int'(hdr[23:0]), bv * BPL);
            end
            was_low = !spi_cs_n;
            p_hs = e_hs; p_vs = e_vs; p_pix = e_pix; p_known = known;
            prev_valid = 1'b1;
        end
    end

    initial begin
        void'($urandom(32'd7331));
        set_timing(1'b0);
        for (int s = 0; s < 7; s++) begin
            bit m, r;
            logic [7:0] k;
            if (s < 4) begin m = s[1]; r = s[0]; end
            else begin m = 1'($urandom % 2); r = 1'($urandom % 2); end
            k = 8'($urandom);
            @(negedge clk);
            rst_n = 1'b0;
            @(negedge clk);
            timing_sel = m; out_reg_en = 1'b0; key = k;
            set_timing(m);
            repeat (2) @(negedge clk);
            // reset state, unregistered outputs
            chk(spi_cs_n == 1'b1, "R4 reset cs", int'(spi_cs_n), 1);
            chk({red, green, blue} == 6'd0, "R9 reset colour", int'({red, green, blue}), 0);
            chk(hsync == !HP, "R2 reset hsync", int'(hsync), int'(!HP));
            chk(vsync == !VP, "R2 reset vsync", int'(vsync), int'(!VP));
            out_reg_en = r;
            @(negedge clk);
            rst_n = 1'b1;
            repeat (3 * HT * VT + HT) @(negedge clk);
        end
        finish_up();
    end
endmodule